// File: doc/BRIEF.md
# MII Transmit Nibble-to-Code-Group Encoder

This block sits between a 100 Mb/s MAC transmit port and the serializer of the physical layer. Once per transmit clock it samples the MAC's enable, error and 4-bit data lines. It then drives a registered 5-bit code group, which the line side shifts out one symbol per clock. Between frames the line carries IDLE. When a frame begins, the first two nibbles are replaced by the start-of-stream pair J and K. The remaining nibbles each map to their 4B5B data code group. When the enable drops, the end-of-stream pair T and R follows, and the line then returns to IDLE.

A transmit error flagged while the enable is high replaces that cycle's symbol with HALT, whether that symbol would have been J, K or data. Outside the enable, both the data and the error line are ignored. A frame that starts again during the R slot takes over that slot with J. Serialization, scrambling, line coding and receive are not part of this block.

Top module: `mii_sym_encoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with the enable low, the code group output is IDLE (11111).
- R2: While the enable is low and no end-of-stream pair is pending, the output is IDLE. Data and error inputs sampled with the enable low have no effect on it.
- R3: The first nibble sampled with the enable high after a low is sent as J (11000). The second nibble of that frame is sent as K (10001).
- R4: Every later nibble in the frame is sent as its 4B5B code group, with data bit 3 as the most significant input bit. The codes for 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: Any clock that samples both the enable and the error high produces HALT (00100) in place of the J, K or data code group. The frame position still advances.
- R6: The first clock that samples the enable low after a frame produces T (01101). The next clock produces R (00111), and IDLE follows after that. This includes a frame only one nibble long, which is sent as J, T, R.
- R7: If the enable is sampled high in the cycle where R would be sent, J is sent instead and a new frame begins.
- R8: Each code group appears on the output one clock after the edge that sampled the inputs it encodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error flag from the MAC |
| txd | input | 4 | Transmit nibble; bit 3 is the most significant |
| code_o | output | 5 | Registered 5-bit code group toward the serializer |

## Verification
Every code group is due exactly one rising edge after the edge that samples its inputs. The frame-position state adds no further delay: J, K, T and R all appear at that same one-clock distance. The bench drives inputs on the falling edge and runs a reference model on what it drove. It compares the output on the following falling edge, which falls after the single register stage. Each check carries a tag for the requirement that produced the expected symbol, covering preemption of R, HALT and reset mid-frame.

// File: rtl/mii_enc_pkg.sv
package mii_enc_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_HALT = 5'b00100;

  // frame position tracked by the framer
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_KPEND = 2'd1,
    FR_DATA  = 2'd2,
    FR_RPEND = 2'd3
  } fr_state_e;

  // which symbol class the current cycle calls for
  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_J    = 3'd1,
    SEL_K    = 3'd2,
    SEL_DATA = 3'd3,
    SEL_T    = 3'd4,
    SEL_R    = 3'd5
  } sel_e;

  // 4B5B data mapping, bit 3 of the nibble is the MSB of the index
  function automatic sym_t nib_to_sym(input nib_t n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // symbols that may be overridden by a transmit error
  function automatic logic sel_is_frame(input sel_e s);
    return (s == SEL_J) || (s == SEL_K) || (s == SEL_DATA);
  endfunction

endpackage

// File: rtl/mii_enc_framer.sv
module mii_enc_framer
  import mii_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  output fr_state_e state_o,
  output sel_e      sel_o,
  output logic      sof_o,
  output logic      eof_o
);

  fr_state_e state_q, state_d;
  sel_e      sel_d;

  always_comb begin
    state_d = state_q;
    sel_d   = SEL_IDLE;
    if (tx_en) begin
      case (state_q)
        FR_KPEND: begin
          sel_d   = SEL_K;
          state_d = FR_DATA;
        end
        FR_DATA: begin
          sel_d   = SEL_DATA;
          state_d = FR_DATA;
        end
        default: begin // idle or R slot: a new frame starts with J
          sel_d   = SEL_J;
          state_d = FR_KPEND;
        end
      endcase
    end else begin
      case (state_q)
        FR_KPEND, FR_DATA: begin
          sel_d   = SEL_T;
          state_d = FR_RPEND;
        end
        FR_RPEND: begin
          sel_d   = SEL_R;
          state_d = FR_IDLE;
        end
        default: begin
          sel_d   = SEL_IDLE;
          state_d = FR_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FR_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign sel_o   = sel_d;
  assign sof_o   = tx_en && ((state_q == FR_IDLE) || (state_q == FR_RPEND));
  assign eof_o   = !tx_en && ((state_q == FR_KPEND) || (state_q == FR_DATA));

  // R3: a frame start always leaves K pending for the next clock
  p_sof_kpend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> (state_o == FR_KPEND));

  // R6: the end of a frame always leaves R pending
  p_eof_rpend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> (state_o == FR_RPEND));

endmodule

// File: rtl/mii_enc_select.sv
module mii_enc_select
  import mii_enc_pkg::*;
(
  input  sel_e  sel_i,
  input  logic  tx_er,
  input  nib_t  txd,
  output sym_t  sym_o,
  output logic  halt_o
);

  sym_t base;

  always_comb begin
    case (sel_i)
      SEL_J:    base = SYM_J;
      SEL_K:    base = SYM_K;
      SEL_DATA: base = nib_to_sym(txd);
      SEL_T:    base = SYM_T;
      SEL_R:    base = SYM_R;
      default:  base = SYM_IDLE;
    endcase
  end

  // error only matters on cycles that carry frame content
  assign halt_o = tx_er && sel_is_frame(sel_i);
  assign sym_o  = halt_o ? SYM_HALT : base;

endmodule

// File: rtl/mii_sym_encoder.sv
module mii_sym_encoder
  import mii_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [SYM_W-1:0] code_o
);

  fr_state_e fr_state;
  sel_e      fr_sel;
  logic      fr_sof;
  logic      fr_eof;
  sym_t      next_sym;
  logic      halt_now;
  sym_t      code_q;

  mii_enc_framer u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .state_o (fr_state),
    .sel_o   (fr_sel),
    .sof_o   (fr_sof),
    .eof_o   (fr_eof)
  );

  mii_enc_select u_select (
    .sel_i  (fr_sel),
    .tx_er  (tx_er),
    .txd    (txd),
    .sym_o  (next_sym),
    .halt_o (halt_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= SYM_IDLE;
    else        code_q <= next_sym;
  end

  assign code_o = code_q;

  // R2: quiet line stays idle whatever data or error show
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && fr_state == FR_IDLE) |=> (code_o == SYM_IDLE));

  // R3: clean frame start is J
  p_start_j_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_sof && !tx_er) |=> (code_o == SYM_J));

  // R4: data nibble appears coded one clock later
  p_data_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_er && fr_state == FR_DATA) |=> (code_o == nib_to_sym($past(txd))));

  // R5: error inside the enable yields HALT
  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_er) |=> (code_o == SYM_HALT));

  // R6: T is followed by R when the enable stays low
  p_t_then_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == SYM_T && !tx_en) |=> (code_o == SYM_R));

  // R8: HALT flag and the registered output agree one clock apart
  p_halt_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_now |=> (code_o == SYM_HALT));

endmodule

// File: tb/mii_sym_encoder_bench.sv
module mii_sym_encoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] code_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  mii_sym_encoder u_mii_sym_encoder (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .code_o(code_o)
  );

  // codes for F down to 0, packed
  localparam logic [79:0] CODE_TBL = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    return CODE_TBL[int'(n)*5 +: 5];
  endfunction

  // reference model: 0 quiet, 1 after first nibble, 2 in data, 3 R owed
  int          m_pos = 0;
  logic [4:0]  exp_sym = 5'b11111;
  string       exp_tag = "R1";

  task automatic model_step(input logic en, input logic er, input logic [3:0] d);
    logic [4:0] s;
    string      t;
    if (en) begin
      if (m_pos == 1)      begin s = 5'b10001; t = "R3"; m_pos = 2; end
      else if (m_pos == 2) begin s = ref_code(d); t = "R4"; end
      else begin
        s = 5'b11000; t = (m_pos == 3) ? "R7" : "R3"; m_pos = 1;
      end
      if (er) begin s = 5'b00100; t = "R5"; end
    end else begin
      if (m_pos == 1 || m_pos == 2) begin s = 5'b01101; t = "R6"; m_pos = 3; end
      else if (m_pos == 3)          begin s = 5'b00111; t = "R6"; m_pos = 0; end
      else                          begin s = 5'b11111; t = "R2"; end
    end
    exp_sym = s;
    exp_tag = t;
  endtask

  task automatic check_out();
    n_checks++;
    if (code_o !== exp_sym) begin
      n_fail++;
      $display("FAIL %s (R8 timing): code_o=%b expected=%b at %0t", exp_tag, code_o, exp_sym, $time);
    end
  endtask

  // one clock of stimulus: verify prior result, then drive new inputs
  task automatic cyc(input logic en, input logic er, input logic [3:0] d);
    @(negedge clk);
    check_out();
    tx_en = en; tx_er = er; txd = d;
    model_step(en, er, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_pos = 0; exp_sym = 5'b11111; exp_tag = "R1";
    tx_en = 1'b1; tx_er = 1'b1; txd = 4'h5;
    @(negedge clk);
    check_out(); // R1: held in reset despite active inputs
    tx_en = 1'b0; tx_er = 1'b0;
    rst_n = 1'b1;
    exp_tag = "R1";
  endtask

  task automatic frame(input int len, input int er_pct);
    for (int i = 0; i < len; i++)
      cyc(1'b1, ($urandom % 100) < er_pct, 4'($urandom));
  endtask

  task automatic gap(input int len);
    for (int i = 0; i < len; i++)
      cyc(1'b0, 1'($urandom), 4'($urandom)); // R2: ignored values
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    do_reset();
    cyc(1'b0, 1'b0, 4'h0);          // R1: IDLE after release
    gap(3);                         // R2
    // R3/R4: all sixteen nibbles in order after J K
    cyc(1'b1, 1'b0, 4'h0);
    cyc(1'b1, 1'b0, 4'h0);
    for (int n = 0; n < 16; n++) cyc(1'b1, 1'b0, 4'(n));
    gap(4);                         // R6 then R2
    // R6: one-nibble frame J T R
    cyc(1'b1, 1'b0, 4'hA);
    gap(3);
    // R7: enable back after one low clock preempts R
    frame(5, 0);
    cyc(1'b0, 1'b0, 4'h0);
    frame(4, 0);
    gap(3);
    // R5: error on J, on K and on data
    cyc(1'b1, 1'b1, 4'h3);
    cyc(1'b1, 1'b1, 4'h3);
    cyc(1'b1, 1'b0, 4'h7);
    cyc(1'b1, 1'b1, 4'h7);
    cyc(1'b1, 1'b0, 4'h9);
    gap(3);
    // R1: reset mid-frame
    frame(6, 0);
    do_reset();
    cyc(1'b0, 1'b0, 4'h0);
    gap(2);
    // constrained random frames and gaps
    for (int f = 0; f < 400; f++) begin
      frame(1 + ($urandom % 24), 6);
      gap(1 + ($urandom % 5));
    end
    cyc(1'b0, 1'b0, 4'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule